// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small in-order CPU core. It collects interrupt requests from a parameterized set of sources and decides which one the core should serve. When a request wins, it hands the core a vector address together with a one-cycle take strobe. Each source has an enable bit, and a single global enable gates all of them. Two kinds of source are supported, chosen per source by a parameter mask. Edge-type sources latch a pending flag. Level-type sources request only while their condition is present.

Accepting a request turns the global enable off. The core's return-from-interrupt pulse turns it back on. After such a return, the core must complete one more instruction before anything new is taken. Software can write the enable register and the global enable. It can also clear edge flags by writing ones. A boot-select input moves the whole vector table from address zero to a boot-section base.

Top module: `irqv_top`

## Requirements
- R1: A request is accepted only while its own enable bit and the global enable are both one. With the global enable at zero, no take strobe occurs even if flags are pending and enabled.
- R2: Among the eligible requests, the lowest source bit wins. Source bit i has vector index i+1, because index 0 is reserved for reset and outranks every source.
- R3: Acceptance produces a take strobe exactly one cycle wide and clears the global enable in the same edge. A pulse on `reti` sets the global enable again.
- R4: An edge-type source sets its pending flag even while disabled. The flag stays set until it is accepted or cleared by software.
- R5: Accepting an edge-type source clears its flag. A flag write clears only the bits written as one and leaves the other flags unchanged.
- R6: A level-type source shows as pending only while its input is high, one cycle delayed. If the input drops before the source is enabled, no interrupt occurs.
- R7: After `reti`, the first `insn_done` is consumed without any acceptance. The earliest acceptance is on the following `insn_done`, and nothing is taken while `insn_done` stays low.
- R8: A global-enable write of zero blocks acceptance in the very cycle it is presented, even when `insn_done` and an eligible request coincide with it.
- R9: The vector address is base + 2 × index. The base is 0 when `vec_boot` is low and the parameter BOOT_BASE when it is high.
- R10: After reset, `take`, `gie` and all pending flags are zero. A global-enable write of one is visible on `gie` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Set pulses (edge-type) or conditions (level-type) from the sources |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | N_SRC | New per-source enable bits |
| flag_clr_wr | input | 1 | Write strobe for flag clearing |
| flag_clr_data | input | N_SRC | Ones clear the matching edge flags |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | New global enable value |
| vec_boot | input | 1 | Selects the boot-section vector base |
| insn_done | input | 1 | The core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| take | output | 1 | One-cycle strobe: jump to vec_addr |
| vec_addr | output | ADDR_W | Vector address of the accepted source |
| gie | output | 1 | Current global enable |
| pending | output | N_SRC | Pending state of each source |

## Verification
A source input sampled at edge P shows on `pending` just after P. If that request is eligible, it is accepted at the next edge where `insn_done` is high, so `take` and `vec_addr` appear just after P+1 when `insn_done` is held high. A global-enable write of one also needs one edge before it can gate an acceptance, so a take follows it by two edges. After `reti`, the take comes no sooner than the second `insn_done` edge. The driver applies stimulus right after a falling edge and pushes each expected vector into a queue. A monitor examines `take` on every falling edge, pops the queue and compares. The direct checks wait the counted number of falling edges before sampling, so every value is read half a cycle after the edge that produced it.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  // Each vector slot is two words wide.
  localparam int unsigned VEC_SHIFT = 1;

  typedef enum logic {
    GATE_ARMED = 1'b0,
    GATE_WAIT  = 1'b1
  } gate_e;
endpackage

// File: rtl/irqv_flags.sv
module irqv_flags #(
  parameter int unsigned N_SRC = 8,
  parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] clr,
  input  logic [N_SRC-1:0] ack,
  output logic [N_SRC-1:0] pend
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic q;
    assign pend[g] = q;
    if (LEVEL_MASK[g]) begin : g_lvl
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= src_req[g];
      end
      AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        !src_req[g] |=> !q); // R6
    end else begin : g_edge
      always_ff @(posedge clk) begin
        if (rst)                  q <= 1'b0;
        else if (src_req[g])      q <= 1'b1;
        else if (clr[g] | ack[g]) q <= 1'b0;
      end
      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (q && !clr[g] && !ack[g]) |=> q); // R4
    end
  end
endmodule

// File: rtl/irqv_pick.sv
module irqv_pick #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] elig,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N_SRC-1:0] grant
);
  // Scan from the top so the lowest eligible bit is written last and wins.
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        any      = 1'b1;
        idx      = IDX_W'(i + 1);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R2
  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    (grant & ~elig) == '0); // R2
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq
  import irqv_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = '0,
  localparam int unsigned IDX_W = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any,
  input  logic [IDX_W-1:0]  idx,
  input  logic              gie_wr,
  input  logic              gie_wdata,
  input  logic              reti,
  input  logic              insn_done,
  input  logic              vec_boot,
  output logic              accept,
  output logic              take,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              gie
);
  gate_e             gate_q;
  logic              gie_q;
  logic              take_q;
  logic [ADDR_W-1:0] vec_q;
  logic              gie_eff;
  logic [ADDR_W-1:0] base;

  // A write of zero closes the gate in the same cycle.
  assign gie_eff = gie_q & ~(gie_wr & ~gie_wdata);
  assign accept  = any & gie_eff & insn_done & (gate_q == GATE_ARMED) & ~take_q;
  assign base    = vec_boot ? BOOT_BASE : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
      gate_q <= GATE_ARMED;
    end else begin
      take_q <= accept;
      if (accept) vec_q <= base + (ADDR_W'(idx) << VEC_SHIFT);
      if (accept)      gie_q <= 1'b0;
      else if (reti)   gie_q <= 1'b1;
      else if (gie_wr) gie_q <= gie_wdata;
      if (reti)                                    gate_q <= GATE_WAIT;
      else if (gate_q == GATE_WAIT && insn_done)   gate_q <= GATE_ARMED;
    end
  end

  assign take     = take_q;
  assign vec_addr = vec_q;
  assign gie      = gie_q;

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    take_q |=> !take_q); // R3
  AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
    take_q |-> !gie_q); // R3
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    !gie_q |=> !take_q); // R1
  AST_DISABLE_NOW: assert property (@(posedge clk) disable iff (rst)
    (gie_wr && !gie_wdata) |=> !take_q); // R8
  AST_RETI_GAP: assert property (@(posedge clk) disable iff (rst)
    (gate_q == GATE_WAIT) |=> !take_q); // R7
endmodule

// File: rtl/irqv_top.sv
module irqv_top #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'hF000,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_req,
  input  logic              en_wr,
  input  logic [N_SRC-1:0]  en_wdata,
  input  logic              flag_clr_wr,
  input  logic [N_SRC-1:0]  flag_clr_data,
  input  logic              gie_wr,
  input  logic              gie_wdata,
  input  logic              vec_boot,
  input  logic              insn_done,
  input  logic              reti,
  output logic              take,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              gie,
  output logic [N_SRC-1:0]  pending
);
  localparam int unsigned IDX_W = $clog2(N_SRC + 1);

  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] ack;
  logic [N_SRC-1:0] grant;
  logic             any;
  logic             accept;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  assign elig = pending & en_q;
  assign clr  = flag_clr_wr ? flag_clr_data : '0;
  assign ack  = accept ? grant : '0;

  irqv_flags #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst(rst), .src_req(src_req), .clr(clr), .ack(ack), .pend(pending)
  );

  irqv_pick #(.N_SRC(N_SRC)) u_pick (
    .clk(clk), .rst(rst), .elig(elig), .any(any), .idx(idx), .grant(grant)
  );

  irqv_seq #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE)) u_seq (
    .clk(clk), .rst(rst), .any(any), .idx(idx), .gie_wr(gie_wr),
    .gie_wdata(gie_wdata), .reti(reti), .insn_done(insn_done),
    .vec_boot(vec_boot), .accept(accept), .take(take),
    .vec_addr(vec_addr), .gie(gie)
  );

  AST_TAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    accept |-> ((pending & en_q) != '0)); // R1
endmodule

// File: tb/irqv_top_test.sv
module irqv_top_test;
  localparam int N = 8;
  localparam logic [15:0] BOOT = 16'hF000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_req = '0;
  logic en_wr = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic flag_clr_wr = 1'b0;
  logic [N-1:0] flag_clr_data = '0;
  logic gie_wr = 1'b0;
  logic gie_wdata = 1'b0;
  logic vec_boot = 1'b0;
  logic insn_done = 1'b1;
  logic reti = 1'b0;
  logic take;
  logic [15:0] vec_addr;
  logic gie;
  logic [N-1:0] pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  irqv_top uut (
    .clk(clk), .rst(rst), .src_req(src_req), .en_wr(en_wr), .en_wdata(en_wdata),
    .flag_clr_wr(flag_clr_wr), .flag_clr_data(flag_clr_data), .gie_wr(gie_wr),
    .gie_wdata(gie_wdata), .vec_boot(vec_boot), .insn_done(insn_done),
    .reti(reti), .take(take), .vec_addr(vec_addr), .gie(gie), .pending(pending)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_vec(input logic [15:0] v);
    exp_q.push_back(v);
  endtask

  // Vector address comparison for every take strobe (R9).
  always @(negedge clk) begin
    if (!rst && take) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1: actual unexpected take at %0h expected none", vec_addr);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (vec_addr !== e) begin
          errors++;
          $display("FAIL R9: actual %0h expected %0h", vec_addr, e);
        end
      end
    end
  end

  task automatic write_gie(input logic v);
    gie_wr = 1'b1; gie_wdata = v; step(1); gie_wr = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    check("R10 take", 32'(take), 0);
    check("R10 gie", 32'(gie), 0);
    check("R10 pending", 32'(pending), 0);

    // R4: flag latches while disabled
    src_req = 8'h04; step(1); src_req = '0; step(3);
    check("R4", 32'(pending), 32'h04);

    // R1: enabled but global enable off
    en_wr = 1'b1; en_wdata = 8'hBF; step(1); en_wr = 1'b0; step(3);
    check("R1", 32'(take), 0);

    // R10 / R3 / R5: bit2 -> index 3 -> vector 6
    expect_vec(16'd6);
    write_gie(1'b1);
    check("R10 gie write", 32'(gie), 1);
    step(1);
    check("R3 take", 32'(take), 1);
    check("R3 gie cleared", 32'(gie), 0);
    check("R5 ack clears", 32'(pending), 0);
    step(1);
    check("R3 one cycle", 32'(take), 0);

    // R2: bits 5 and 1 together, bit1 wins
    src_req = 8'h22; step(1); src_req = '0;
    expect_vec(16'd4);
    write_gie(1'b1);
    step(1);
    check("R2 take", 32'(take), 1);
    check("R2 remaining", 32'(pending), 32'h20);

    // R7: gap after return
    reti = 1'b1; step(1); reti = 1'b0; insn_done = 1'b0;
    check("R3 reti sets gie", 32'(gie), 1);
    check("R7 no take", 32'(take), 0);
    step(3);
    check("R7 idle core", 32'(take), 0);
    insn_done = 1'b1; step(1);
    check("R7 one instruction", 32'(take), 0);
    expect_vec(16'd12);
    step(1);
    check("R7 take after gap", 32'(take), 1);

    // R6: level source vanishes before enable
    write_gie(1'b1);
    src_req = 8'h40; step(2);
    check("R6 level seen", 32'(pending), 32'h40);
    src_req = '0; step(1);
    check("R6 level gone", 32'(pending), 0);
    en_wr = 1'b1; en_wdata = 8'hFF; step(1); en_wr = 1'b0; step(3);
    check("R6 no take", 32'(take), 0);
    check("R6 gie kept", 32'(gie), 1);
    src_req = 8'h40; expect_vec(16'd14); step(2);
    check("R6 level take", 32'(take), 1);
    src_req = '0; step(2);

    // R8: disable in the same cycle as an eligible boundary
    insn_done = 1'b0;
    src_req = 8'h01; step(1); src_req = '0;
    write_gie(1'b1);
    step(1);
    check("R8 held", 32'(take), 0);
    insn_done = 1'b1; gie_wr = 1'b1; gie_wdata = 1'b0; step(1); gie_wr = 1'b0;
    step(1);
    check("R8 take", 32'(take), 0);
    check("R8 gie", 32'(gie), 0);
    check("R8 pending", 32'(pending), 32'h01);

    // R5: write-one-to-clear touches only written ones
    src_req = 8'h08; step(1); src_req = '0;
    check("R5 both set", 32'(pending), 32'h09);
    flag_clr_wr = 1'b1; flag_clr_data = 8'h01; step(1); flag_clr_wr = 1'b0;
    check("R5 partial clear", 32'(pending), 32'h08);
    flag_clr_wr = 1'b1; flag_clr_data = 8'h08; step(1); flag_clr_wr = 1'b0;
    check("R5 full clear", 32'(pending), 0);

    // R9: boot base, bit3 -> index 4 -> BOOT + 8
    vec_boot = 1'b1;
    src_req = 8'h08; step(1); src_req = '0;
    expect_vec(BOOT + 16'd8);
    write_gie(1'b1);
    step(1);
    check("R9 boot take", 32'(take), 1);
    step(3);
    check("R9 queue drained", 32'(exp_q.size()), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule